// File: doc/BRIEF.md
# Programmable gated clock divider

This block derives a slower clock from its input clock by dividing by a programmable integer. A divider value of zero holds the output low, so one field serves as both gate and ratio. Any nonzero value N gives a period of N+1 input cycles.

A second, optional field sets how many input cycles of each period the output stays high. The parameter `HAS_HIGH` builds this field in, and the `high_en` input turns it on at run time. When the field is absent or not enabled, the output runs at about half duty.

The output clock and a one-cycle period-start strobe both come straight from flops. New settings take effect only at a period boundary, so no short pulse ever appears on the output.

Top module: `clk_ratio_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `clk_out` and `period_start` are low.
- R2: While `div_val` is 0 at a period boundary, the output is gated: `clk_out` stays low and `period_start` does not pulse.
- R3: A `div_val` value N of 1 or more gives an output period of exactly N+1 input cycles, measured between successive `period_start` pulses. The smallest ratio is 2 (N=1). The largest is 2^DIV_W, reached when `div_val` is all ones.
- R4: With `HAS_HIGH`=1 and `high_en`=1, `high_val` H is zero-based: for H ≤ N the output is high for the first H+1 cycles of each period and low for the rest.
- R5: With the high-time field in use and H > N, H is treated as N, so the output is high for the whole period.
- R6: With `high_en`=0, or with `HAS_HIGH`=0, `high_val` has no effect and the output is high for floor((N+1)/2) cycles of each period.
- R7: `period_start` is high for exactly one input cycle, the first cycle of each period, and `clk_out` is high in that cycle.
- R8: `div_val`, `high_val` and `high_en` are sampled only at the start of a period. A change in mid-period leaves the current period's length and high time unchanged and applies from the next period.
- R9: When `div_val` goes from 0 to a nonzero value while the output is gated, the first period begins at the next `clk_in` edge, with `clk_out` and `period_start` going high there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_val | input | DIV_W | Divider field: 0 gates the output, N divides by N+1 |
| high_val | input | DIV_W | Zero-based high-time field |
| high_en | input | 1 | Selects the high-time field over the half-period default |
| clk_out | output | 1 | Registered divided clock |
| period_start | output | 1 | One-cycle strobe on the first cycle of each period |

## Verification
The bench builds two instances with DIV_W=4: one with `HAS_HIGH`=1 and one with `HAS_HIGH`=0. At this width the full ratio range from 2 to 16 can be reached, and random draws hit both the all-ones ratio and high-time values above N.

The second instance shows that the half-period default (R6) ignores `high_val`. Directed cases cover the gated state, the restart from zero, and changes made in mid-period.

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen #(
  parameter int DIV_W    = 4,
  parameter bit HAS_HIGH = 1'b1
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic [DIV_W-1:0] high_val,
  input  logic             high_en,
  output logic             clk_out,
  output logic             period_start
);

  logic [DIV_W-1:0] cnt, cur_n, cur_hl;
  logic             running;

  logic             at_end;
  logic             use_hi;
  logic [DIV_W:0]   div_p1;
  logic [DIV_W:0]   half_len;
  logic [DIV_W-1:0] hl_half, hl_prog, new_hl, cnt_nx;

  assign at_end   = !running || (cnt == cur_n);
  assign use_hi   = HAS_HIGH ? high_en : 1'b0;
  assign div_p1   = {1'b0, div_val} + 1'b1;
  assign half_len = div_p1 >> 1;
  assign hl_half  = half_len[DIV_W-1:0] - 1'b1;
  assign hl_prog  = (high_val > div_val) ? div_val : high_val;
  assign new_hl   = use_hi ? hl_prog : hl_half;
  assign cnt_nx   = cnt + 1'b1;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      cur_n        <= '0;
      cur_hl       <= '0;
      running      <= 1'b0;
      clk_out      <= 1'b0;
      period_start <= 1'b0;
    end else if (at_end) begin
      cnt <= '0;
      if (div_val == '0) begin
        running      <= 1'b0;
        clk_out      <= 1'b0;
        period_start <= 1'b0;
      end else begin
        running      <= 1'b1;
        cur_n        <= div_val;
        cur_hl       <= new_hl;
        clk_out      <= 1'b1;
        period_start <= 1'b1;
      end
    end else begin
      cnt          <= cnt_nx;
      clk_out      <= (cnt_nx <= cur_hl);
      period_start <= 1'b0;
    end
  end

  AST_GATED_QUIET: assert property (@(posedge clk_in) disable iff (!rst_n)
    !running |-> (!clk_out && !period_start)); // R2

  AST_CNT_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
    running |-> (cnt <= cur_n)); // R3

  AST_STROBE_HIGH: assert property (@(posedge clk_in) disable iff (!rst_n)
    period_start |-> (clk_out && cnt == '0)); // R7

  AST_STROBE_SINGLE: assert property (@(posedge clk_in) disable iff (!rst_n)
    period_start |=> !period_start); // R7

  AST_HOLD_SETTINGS: assert property (@(posedge clk_in) disable iff (!rst_n)
    (running && !at_end) |=> ($stable(cur_n) && $stable(cur_hl))); // R8

  AST_TAIL_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
    (running && cnt == cur_n && cur_hl < cur_n) |-> !clk_out); // R4

  AST_HIGH_LIMIT: assert property (@(posedge clk_in) disable iff (!rst_n)
    running |-> (cur_hl <= cur_n)); // R5

endmodule

// File: tb/test_clk_ratio_gen.sv
module test_clk_ratio_gen;
  localparam int W = 4;
  localparam time CLK_PER = 10;

  logic clk_in = 1'b0, rst_n = 1'b0;
  logic [W-1:0] div_val = '0, high_val = '0;
  logic high_en = 1'b0;
  logic out_a, ps_a, out_b, ps_b;
  logic sel = 1'b0;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  always #(CLK_PER/2) clk_in = ~clk_in;

  clk_ratio_gen #(.DIV_W(W), .HAS_HIGH(1'b1)) i_clk_ratio_gen (
    .clk_in(clk_in), .rst_n(rst_n), .div_val(div_val), .high_val(high_val),
    .high_en(high_en), .clk_out(out_a), .period_start(ps_a));

  clk_ratio_gen #(.DIV_W(W), .HAS_HIGH(1'b0)) i_clk_ratio_gen_nohi (
    .clk_in(clk_in), .rst_n(rst_n), .div_val(div_val), .high_val(high_val),
    .high_en(high_en), .clk_out(out_b), .period_start(ps_b));

  function automatic logic cur_out(); return sel ? out_b : out_a; endfunction
  function automatic logic cur_ps();  return sel ? ps_b : ps_a;  endfunction

  function automatic int exp_high(int n, int h, logic en, logic has);
    if (has && en) return (h > n) ? n + 1 : h + 1;
    return (n + 1) / 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_in);
      if (cur_ps()) return;
    end
    chk("R7 strobe timeout", 0, 1);
  endtask

  task automatic measure(output int len, output int hi);
    len = 1; hi = cur_out() ? 1 : 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_in);
      if (cur_ps()) return;
      len++;
      if (cur_out()) hi++;
    end
  endtask

  task automatic trial(string req, int n, int h, logic en);
    int len, hi;
    @(negedge clk_in);
    div_val = W'(n); high_val = W'(h); high_en = en;
    wait_strobe();
    measure(len, hi);
    chk({req, " period"}, len, n + 1);
    chk({req, " high"}, hi, exp_high(n, h, en, !sel));
  endtask

  initial begin
    int len, hi, n, h;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_in);
    chk("R1 out in reset", out_a, 0);
    chk("R1 strobe in reset", ps_a, 0);
    rst_n = 1'b1;
    @(negedge clk_in);
    chk("R1 out after reset", out_a, 0);
    chk("R1 strobe after reset", ps_a, 0);

    for (int i = 0; i < 20; i++) begin
      @(negedge clk_in);
      if (out_a || ps_a) begin chk("R2 gated", 1, 0); break; end
    end
    checks++;

    @(negedge clk_in);
    div_val = 4'd3; high_val = 4'd1; high_en = 1'b1;
    @(negedge clk_in);
    chk("R9 first strobe", ps_a, 1);
    chk("R9 first high", out_a, 1);

    trial("R3 min", 1, 0, 1'b1);
    trial("R3 max", 15, 4, 1'b1);
    trial("R4 duty", 7, 2, 1'b1);
    trial("R5 clamp", 5, 12, 1'b1);
    trial("R6 half odd", 6, 1, 1'b0);
    trial("R6 half even", 9, 0, 1'b0);

    for (int i = 0; i < 40; i++) begin
      n = 1 + int'($urandom_range(14));
      h = int'($urandom_range(15));
      trial("R4 random", n, h, 1'($urandom_range(1)));
    end

    @(negedge clk_in);
    div_val = 4'd4; high_val = 4'd1; high_en = 1'b1;
    wait_strobe();
    @(negedge clk_in);
    div_val = 4'd10; high_val = 4'd8;
    len = 2; hi = (out_a ? 1 : 0) + 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_in);
      if (ps_a) break;
      len++; if (out_a) hi++;
    end
    chk("R8 old period", len, 5);
    chk("R8 old high", hi, 2);
    measure(len, hi);
    chk("R8 new period", len, 11);
    chk("R8 new high", hi, 9);

    @(negedge clk_in);
    div_val = 4'd0;
    repeat (20) @(negedge clk_in);
    chk("R2 gated out", out_a, 0);
    chk("R2 gated strobe", ps_a, 0);

    sel = 1'b1;
    trial("R6 no field", 7, 1, 1'b1);
    for (int i = 0; i < 10; i++) begin
      n = 1 + int'($urandom_range(14));
      trial("R6 no field random", n, int'($urandom_range(15)), 1'b1);
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk_in);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0 expected=1");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule